// File: doc/BRIEF.md
# UART Channel Command Decoder

This block sits behind the host bus of a two-channel serial controller and interprets byte writes aimed at either channel's command location. The low four bits of a byte switch the receiver and transmitter of the addressed channel on or off. The high four bits select at most one command. Commands with bit 7 clear are the base set: pointer, receiver, transmitter, error and break-change resets, plus two break codes that have no effect here. Commands with bit 7 set are the extension: request-to-send drive, receive timeout mode on or off, and a chip-wide power-down switch. Both halves of the byte take effect in the same write.

Level outputs (enables, active-low RTS, timeout mode, power-down) are registered flags. Reset commands leave the block as one-clock pulses for the serial datapath, which lies outside this block. All changes take effect at the rising clock edge where `wr_en` is sampled high. Pulses are high for exactly the following clock cycle.

Top module: `uart_cmd_decoder`

## Requirements
- R1: After the asynchronous reset (`rst_n` low), every channel's receiver and transmitter are disabled, `rts_n` is high, timeout mode is off, `pwr_down` is low and no pulse is active.
- R2: In a write, bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. A disable bit wins over its enable bit. Only the channel given by `wr_ch` (0 = A, 1 = B) changes.
- R3: High nibble 0x2 pulses `rx_rst_pulse` and high nibble 0x3 pulses `tx_rst_pulse` for the addressed channel. Either reset clears its own enable first, and the low nibble of the same byte then applies (0x35 leaves the transmitter enabled).
- R4: High nibble 0x1 pulses `ptr_rst_pulse`, 0x4 pulses `err_rst_pulse` and 0x5 pulses `brk_rst_pulse`. High nibbles 0x0, 0x6, 0x7, 0xB and 0xD change nothing beyond what the low nibble does.
- R5: High nibble 0x8 drives the channel's `rts_n` low, and 0x9 drives it high.
- R6: High nibble 0xA sets the channel's `rx_tmo_mode`, and 0xC clears it.
- R7: High nibble 0xE sets `pwr_down` and 0xF clears it, but only when written to channel A (index 0). On channel B these two codes leave `pwr_down` unchanged.
- R8: State changes only on a write. While `pwr_down` is high, all flags keep their values and commands are still accepted.
- R9: A byte with bit 7 clear decodes exactly as in the base command set. No extended action occurs for it.
- R10: Every reset pulse is high for exactly the one cycle after its write, and all pulses are low in any cycle that does not follow a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one byte per high cycle |
| wr_ch | input | CH_W (1) | Target channel, 0 = A, 1 = B |
| wr_data | input | 8 | Command byte |
| rx_en | output | NUM_CH | Receiver enable per channel |
| tx_en | output | NUM_CH | Transmitter enable per channel |
| rts_n | output | NUM_CH | Active-low request-to-send per channel |
| rx_tmo_mode | output | NUM_CH | Receive timeout mode per channel |
| pwr_down | output | 1 | Chip-wide power-down level |
| rx_rst_pulse | output | NUM_CH | Receiver reset pulse |
| tx_rst_pulse | output | NUM_CH | Transmitter reset pulse |
| ptr_rst_pulse | output | NUM_CH | Mode-pointer reset pulse |
| err_rst_pulse | output | NUM_CH | Error status reset pulse |
| brk_rst_pulse | output | NUM_CH | Break-change reset pulse |

## Verification
The hardest case to reach is an interaction between the command in the high nibble and the enable bits in the low nibble. It shows up only when the channel already holds the opposite enable state, for example a transmitter reset combined with an enable on a channel that is already running. The bench therefore writes each of the 256 bytes to each channel after each of four preparatory bytes that leave the enables, RTS and timeout flags in different states. An arithmetic model predicts every output after every write. A separate sequence enters power-down with a distinctive state, idles with random data on the bus, writes while powered down, and then leaves power-down.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

    // High-nibble command codes
    typedef enum logic [3:0] {
        OP_NONE    = 4'h0,
        OP_PTR_RST = 4'h1,
        OP_RX_RST  = 4'h2,
        OP_TX_RST  = 4'h3,
        OP_ERR_RST = 4'h4,
        OP_BRK_RST = 4'h5,
        OP_BRK_ON  = 4'h6,
        OP_BRK_OFF = 4'h7,
        OP_RTS_LO  = 4'h8,
        OP_RTS_HI  = 4'h9,
        OP_TMO_ON  = 4'hA,
        OP_RSV_B   = 4'hB,
        OP_TMO_OFF = 4'hC,
        OP_RSV_D   = 4'hD,
        OP_PD_ON   = 4'hE,
        OP_PD_OFF  = 4'hF
    } cmd_op_e;

    // Per-channel actions decoded from one byte
    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic err_rst;
        logic brk_rst;
        logic rts_lo;
        logic rts_hi;
        logic tmo_on;
        logic tmo_off;
        logic rx_set;
        logic rx_clr;
        logic tx_set;
        logic tx_clr;
    } chan_act_t;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
        logic rts_n;
        logic tmo;
    } chan_lvl_t;

    typedef struct packed {
        logic ptr;
        logic rx;
        logic tx;
        logic err;
        logic brk;
    } chan_pls_t;

    typedef struct packed {
        chan_lvl_t lvl;
        chan_pls_t pls;
    } chan_state_t;

    localparam chan_state_t CHAN_RESET = '{
        lvl: '{rx_en: 1'b0, tx_en: 1'b0, rts_n: 1'b1, tmo: 1'b0},
        pls: '0
    };

endpackage

// File: rtl/uart_cmd_opdec.sv
module uart_cmd_opdec
    import uart_cmd_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic [CMD_W-1:0] cmd_byte,
    output chan_act_t        act,
    output logic             pd_on,
    output logic             pd_off
);
    localparam int NIB_LO = CMD_W / 2;

    cmd_op_e op;

    always_comb begin
        op     = cmd_op_e'(cmd_byte[CMD_W-1:NIB_LO]);
        act    = '0;
        pd_on  = 1'b0;
        pd_off = 1'b0;
        unique case (op)
            OP_PTR_RST: act.ptr_rst = 1'b1;
            OP_RX_RST:  act.rx_rst  = 1'b1;
            OP_TX_RST:  act.tx_rst  = 1'b1;
            OP_ERR_RST: act.err_rst = 1'b1;
            OP_BRK_RST: act.brk_rst = 1'b1;
            OP_RTS_LO:  act.rts_lo  = 1'b1;
            OP_RTS_HI:  act.rts_hi  = 1'b1;
            OP_TMO_ON:  act.tmo_on  = 1'b1;
            OP_TMO_OFF: act.tmo_off = 1'b1;
            OP_PD_ON:   pd_on       = 1'b1;
            OP_PD_OFF:  pd_off      = 1'b1;
            default:    ;
        endcase
        // low nibble: enable/disable bits
        act.rx_set = cmd_byte[0];
        act.rx_clr = cmd_byte[1];
        act.tx_set = cmd_byte[2];
        act.tx_clr = cmd_byte[3];
    end
endmodule

// File: rtl/uart_cmd_chan.sv
module uart_cmd_chan
    import uart_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  chan_act_t   act,
    output chan_state_t state
);
    chan_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.pls = '0;
        if (sel) begin
            state_d.pls.ptr = act.ptr_rst;
            state_d.pls.rx  = act.rx_rst;
            state_d.pls.tx  = act.tx_rst;
            state_d.pls.err = act.err_rst;
            state_d.pls.brk = act.brk_rst;
            // resets clear their own enable before the low nibble applies
            if (act.rx_rst)  state_d.lvl.rx_en = 1'b0;
            if (act.tx_rst)  state_d.lvl.tx_en = 1'b0;
            if (act.rts_lo)  state_d.lvl.rts_n = 1'b0;
            if (act.rts_hi)  state_d.lvl.rts_n = 1'b1;
            if (act.tmo_on)  state_d.lvl.tmo   = 1'b1;
            if (act.tmo_off) state_d.lvl.tmo   = 1'b0;
            // disable wins over enable
            if (act.rx_set)  state_d.lvl.rx_en = 1'b1;
            if (act.rx_clr)  state_d.lvl.rx_en = 1'b0;
            if (act.tx_set)  state_d.lvl.tx_en = 1'b1;
            if (act.tx_clr)  state_d.lvl.tx_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CHAN_RESET;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/uart_cmd_decoder.sv
module uart_cmd_decoder
    import uart_cmd_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CMD_W  = 8,
    parameter int PD_CH  = 0,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [CMD_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] rx_en,
    output logic [NUM_CH-1:0] tx_en,
    output logic [NUM_CH-1:0] rts_n,
    output logic [NUM_CH-1:0] rx_tmo_mode,
    output logic              pwr_down,
    output logic [NUM_CH-1:0] rx_rst_pulse,
    output logic [NUM_CH-1:0] tx_rst_pulse,
    output logic [NUM_CH-1:0] ptr_rst_pulse,
    output logic [NUM_CH-1:0] err_rst_pulse,
    output logic [NUM_CH-1:0] brk_rst_pulse
);
    chan_act_t act;
    logic      pd_on, pd_off;

    uart_cmd_opdec #(.CMD_W(CMD_W)) i_opdec (
        .cmd_byte (wr_data),
        .act      (act),
        .pd_on    (pd_on),
        .pd_off   (pd_off)
    );

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        chan_state_t st;
        logic        sel;

        assign sel = wr_en && (wr_ch == CH_W'(gi));

        uart_cmd_chan i_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel),
            .act   (act),
            .state (st)
        );

        assign rx_en[gi]         = st.lvl.rx_en;
        assign tx_en[gi]         = st.lvl.tx_en;
        assign rts_n[gi]         = st.lvl.rts_n;
        assign rx_tmo_mode[gi]   = st.lvl.tmo;
        assign rx_rst_pulse[gi]  = st.pls.rx;
        assign tx_rst_pulse[gi]  = st.pls.tx;
        assign ptr_rst_pulse[gi] = st.pls.ptr;
        assign err_rst_pulse[gi] = st.pls.err;
        assign brk_rst_pulse[gi] = st.pls.brk;
    end

    // chip-wide power-down flag, controlled from one channel only
    logic pd_sel;
    logic pd_d, pd_q;

    assign pd_sel = wr_en && (wr_ch == CH_W'(PD_CH));

    always_comb begin
        pd_d = pd_q;
        if (pd_sel && pd_on)  pd_d = 1'b1;
        if (pd_sel && pd_off) pd_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pd_q <= 1'b0;
        else        pd_q <= pd_d;
    end

    assign pwr_down = pd_q;
endmodule

// File: rtl/uart_cmd_decoder_chk.sv
module uart_cmd_decoder_chk #(
    parameter int NUM_CH = 2,
    parameter int CMD_W  = 8,
    parameter int PD_CH  = 0,
    parameter int CH_W   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CH_W-1:0]   wr_ch,
    input logic [CMD_W-1:0]  wr_data,
    input logic [NUM_CH-1:0] rx_en,
    input logic [NUM_CH-1:0] tx_en,
    input logic [NUM_CH-1:0] rts_n,
    input logic [NUM_CH-1:0] rx_tmo_mode,
    input logic              pwr_down,
    input logic [NUM_CH-1:0] rx_rst_pulse,
    input logic [NUM_CH-1:0] tx_rst_pulse,
    input logic [NUM_CH-1:0] ptr_rst_pulse,
    input logic [NUM_CH-1:0] err_rst_pulse,
    input logic [NUM_CH-1:0] brk_rst_pulse
);
    localparam int HI = CMD_W - 1;
    localparam int LO = CMD_W / 2;

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chk
        assert_rx_rst_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
            rx_rst_pulse[gi] |-> $past(wr_en) && $past(wr_ch) == CH_W'(gi)
                                 && $past(wr_data[HI:LO]) == 4'h2);

        assert_tx_rst_then_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
            tx_rst_pulse[gi] |-> tx_en[gi] == ($past(wr_data[2]) && !$past(wr_data[3])));

        assert_rx_disable_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wr_en) && $past(wr_ch) == CH_W'(gi) && $past(wr_data[1])) |-> !rx_en[gi]);

        assert_rts_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rts_n[gi]) |-> $past(wr_en) && $past(wr_ch) == CH_W'(gi)
                                 && $past(wr_data[HI:LO]) == 4'h8);

        assert_tmo_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rx_tmo_mode[gi]) |-> $past(wr_en) && $past(wr_data[HI:LO]) == 4'hA);
    end

    assert_pd_only_chan_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> $past(wr_en) && $past(wr_ch) == CH_W'(PD_CH)
                            && $past(wr_data[HI:LO]) == 4'hE);

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(rx_en) && $stable(tx_en) && $stable(rts_n)
                          && $stable(rx_tmo_mode) && $stable(pwr_down));

    assert_idle_no_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> (rx_rst_pulse | tx_rst_pulse | ptr_rst_pulse
                           | err_rst_pulse | brk_rst_pulse) == '0);
endmodule

bind uart_cmd_decoder uart_cmd_decoder_chk #(
    .NUM_CH (NUM_CH),
    .CMD_W  (CMD_W),
    .PD_CH  (PD_CH),
    .CH_W   (CH_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_ch         (wr_ch),
    .wr_data       (wr_data),
    .rx_en         (rx_en),
    .tx_en         (tx_en),
    .rts_n         (rts_n),
    .rx_tmo_mode   (rx_tmo_mode),
    .pwr_down      (pwr_down),
    .rx_rst_pulse  (rx_rst_pulse),
    .tx_rst_pulse  (tx_rst_pulse),
    .ptr_rst_pulse (ptr_rst_pulse),
    .err_rst_pulse (err_rst_pulse),
    .brk_rst_pulse (brk_rst_pulse)
);

// File: tb/test_uart_cmd_decoder.sv
`timescale 1ns/1ps
module test_uart_cmd_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] wr_ch = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rx_en, tx_en, rts_n, rx_tmo_mode;
    logic       pwr_down;
    logic [1:0] rx_rst_pulse, tx_rst_pulse, ptr_rst_pulse, err_rst_pulse, brk_rst_pulse;

    int n_cmp = 0;
    int n_bad = 0;

    // expected model
    logic [1:0] m_rx, m_tx, m_rts, m_tmo;
    logic       m_pd;
    logic [1:0] m_prx, m_ptx, m_pptr, m_perr, m_pbrk;

    always #2.5 clk = ~clk;

    uart_cmd_decoder i_uart_cmd_decoder (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_ch (wr_ch), .wr_data (wr_data),
        .rx_en (rx_en), .tx_en (tx_en), .rts_n (rts_n), .rx_tmo_mode (rx_tmo_mode),
        .pwr_down (pwr_down), .rx_rst_pulse (rx_rst_pulse), .tx_rst_pulse (tx_rst_pulse),
        .ptr_rst_pulse (ptr_rst_pulse), .err_rst_pulse (err_rst_pulse),
        .brk_rst_pulse (brk_rst_pulse)
    );

    function automatic logic [18:0] actual();
        return {rx_en, tx_en, rts_n, rx_tmo_mode, pwr_down,
                rx_rst_pulse, tx_rst_pulse, ptr_rst_pulse, err_rst_pulse, brk_rst_pulse};
    endfunction

    function automatic logic [18:0] expected();
        return {m_rx, m_tx, m_rts, m_tmo, m_pd, m_prx, m_ptx, m_pptr, m_perr, m_pbrk};
    endfunction

    task automatic compare(input string tag);
        n_cmp++;
        if (actual() !== expected()) begin
            n_bad++;
            $display("FAIL %s: actual %05h expected %05h", tag, actual(), expected());
        end
    endtask

    function automatic void clear_pulses();
        m_prx = '0; m_ptx = '0; m_pptr = '0; m_perr = '0; m_pbrk = '0;
    endfunction

    function automatic void model_reset();
        m_rx = '0; m_tx = '0; m_rts = '1; m_tmo = '0; m_pd = 1'b0;
        clear_pulses();
    endfunction

    // requirement arithmetic for one write
    function automatic void model_write(input int ch, input logic [7:0] b);
        clear_pulses();
        case (b[7:4])
            4'h1: m_pptr[ch] = 1'b1;
            4'h2: begin m_prx[ch] = 1'b1; m_rx[ch] = 1'b0; end
            4'h3: begin m_ptx[ch] = 1'b1; m_tx[ch] = 1'b0; end
            4'h4: m_perr[ch] = 1'b1;
            4'h5: m_pbrk[ch] = 1'b1;
            4'h8: m_rts[ch] = 1'b0;
            4'h9: m_rts[ch] = 1'b1;
            4'hA: m_tmo[ch] = 1'b1;
            4'hC: m_tmo[ch] = 1'b0;
            4'hE: if (ch == 0) m_pd = 1'b1;
            4'hF: if (ch == 0) m_pd = 1'b0;
            default: ;
        endcase
        if (b[0]) m_rx[ch] = 1'b1;
        if (b[1]) m_rx[ch] = 1'b0;
        if (b[2]) m_tx[ch] = 1'b1;
        if (b[3]) m_tx[ch] = 1'b0;
    endfunction

    function automatic string tag_of(input logic [7:0] b);
        string t;
        case (b[7:4])
            4'h0:             t = "R2";
            4'h2, 4'h3:       t = "R3";
            4'h8, 4'h9:       t = "R5";
            4'hA, 4'hC:       t = "R6";
            4'hE, 4'hF:       t = "R7";
            default:          t = "R4";
        endcase
        if (!b[7]) t = {t, " R9"};
        return t;
    endfunction

    // one write: drive at negedge, check one cycle later; pulses must be gone before next write
    task automatic do_write(input int ch, input logic [7:0] b);
        @(negedge clk);
        compare($sformatf("R10 idle before ch%0d byte %02h", ch, b));
        wr_en = 1'b1; wr_ch = 1'(ch); wr_data = b;
        model_write(ch, b);
        @(negedge clk);
        wr_en = 1'b0;
        compare($sformatf("%s ch%0d byte %02h", tag_of(b), ch, b));
        clear_pulses();
    endtask

    function automatic logic [7:0] prep_byte(input int p);
        case (p)
            0: return 8'h05;
            1: return 8'h8A;
            2: return 8'hA1;
            default: return 8'h94;
        endcase
    endfunction

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");

        // sweep every byte, both channels, four prior states
        for (int ch = 0; ch < 2; ch++) begin
            for (int b = 0; b < 256; b++) begin
                for (int p = 0; p < 4; p++) begin
                    do_write(ch, prep_byte(p));
                    do_write(ch, 8'(b));
                end
            end
        end

        // power-down keeps everything and still accepts commands
        do_write(0, 8'hF0);
        do_write(0, 8'h05);
        do_write(1, 8'h84);
        do_write(1, 8'hA0);
        do_write(1, 8'hE0);   // ignored on channel B
        do_write(0, 8'hE0);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            wr_ch = 1'(k); wr_data = 8'(k * 37 + 11);
        end
        @(negedge clk);
        compare("R8 held during power-down idle");
        do_write(1, 8'h9A);
        do_write(1, 8'hF0);   // ignored on channel B
        do_write(0, 8'hF0);
        compare("R8 state after leaving power-down");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule